// File: doc/BRIEF.md
# Microcoded ALU and T/L Datapath Slice

This block is the arithmetic heart of a microcoded 16-bit processor. Each cycle, the microinstruction supplies a 4-bit ALU function code and two load flags. The processor bus supplies one operand and the T register supplies the other. The block works out the ALU result and its carry out within the cycle. At the clock edge it writes T, L and a latched carry.

The function code does two jobs. It picks the operation, and it also picks whether a T load takes the ALU result or the raw bus value. One function adds the complement of a skip input to the bus, so microcode can step past an instruction on a condition.

A shifter sits after the L register and works on the value already in L. It can pass L through, shift left by one, shift right by one, or swap the two bytes. It reports a negative flag and a zero flag for branch conditions. The bus is a wired-AND of its sources, so when nothing drives it the block sees all ones.

Top module: `alu_tl_datapath`

## Requirements
- R1: The logic and pass functions give these results, with carry out 0: code 0 gives BUS, 1 gives T, 2 gives BUS|T, 3 gives BUS&T, 4 gives BUS^T, 12 gives BUS&T, and 13 gives BUS&~T.
- R2: The arithmetic functions give a result modulo 2^16, with the carry out equal to bit 16 of the sum. Code 5 is BUS+1 and code 6 is BUS+0xFFFF. Code 7 is BUS+T and code 10 is BUS+T+1. Code 8 is BUS+~T+1 and code 9 is BUS+~T.
- R3: Code 11 computes BUS+(skip?0:1). When skip_i=1 it gives BUS unchanged with carry 0. When skip_i=0 it gives BUS+1, with the carry out taken from bit 16.
- R4: Codes 14 and 15 give a result of 0 and a carry of 0. A T load under these codes takes the bus value.
- R5: When load_t_i=1, T takes the ALU result at the next clock edge for codes 0, 2, 5, 6, 10, 11 and 12. For every other code it takes the effective bus value.
- R6: When load_t_i=0, T holds its value.
- R7: When load_l_i=1, L takes the ALU result at the next clock edge. Otherwise L holds its value.
- R8: The latched carry takes the ALU carry out on every edge where L is loaded, and holds its value otherwise.
- R9: When bus_drive_i=0, the effective bus value is 0xFFFF, whatever bus_i carries.
- R10: The shifter output follows shift_op_i. Code 0 passes L through. Code 1 gives L shifted left by one with 0 filled in at bit 0. Code 2 gives L shifted right by one with 0 filled in at bit 15. Code 3 gives L with its two bytes swapped.
- R11: shift_neg_o equals bit 15 of the shifter output. shift_zero_o is 1 exactly when the shifter output is 0.
- R12: While rst_ni is low, T, L and the latched carry are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| aluf_i | input | 4 | ALU function code |
| bus_i | input | 16 | Bus value from the driving source |
| bus_drive_i | input | 1 | High when some source drives the bus |
| skip_i | input | 1 | Skip term used by code 11 |
| load_t_i | input | 1 | Load T at the clock edge |
| load_l_i | input | 1 | Load L and the carry latch at the clock edge |
| shift_op_i | input | 2 | Shifter mode |
| alu_o | output | 16 | ALU result of this cycle |
| carry_o | output | 1 | ALU carry out of this cycle |
| t_o | output | 16 | T register |
| l_o | output | 16 | L register |
| carry_q_o | output | 1 | Latched carry |
| shift_o | output | 16 | Shifter output |
| shift_neg_o | output | 1 | Shifter output is negative |
| shift_zero_o | output | 1 | Shifter output is zero |

## Verification
The assertions check on every cycle the properties that need no arithmetic model. These are: T, L and the latched carry hold when their load flags are low. L and the carry latch take the previous cycle's ALU outputs. The reserved codes give zero. An undriven bus reads as all ones. The fill bits and bit count of the shifter modes are correct, and the shifter flags agree with its output. The per-code arithmetic values, the exact carry edges of subtraction, and the T source chosen by each code can only be shown by the bench scenarios. Those scenarios compare every cycle against a reference model, using random operands and operand pairs at the carry boundaries.

// File: rtl/alu_dp_pkg.sv
package alu_dp_pkg;

  typedef enum logic [3:0] {
    FN_PASS_BUS = 4'd0,
    FN_PASS_T   = 4'd1,
    FN_OR       = 4'd2,
    FN_AND      = 4'd3,
    FN_XOR      = 4'd4,
    FN_INC      = 4'd5,
    FN_DEC      = 4'd6,
    FN_ADD      = 4'd7,
    FN_SUB      = 4'd8,
    FN_SUB_DEC  = 4'd9,
    FN_ADD_INC  = 4'd10,
    FN_ADD_SKIP = 4'd11,
    FN_AND_ALT  = 4'd12,
    FN_AND_NOT  = 4'd13,
    FN_RSV_E    = 4'd14,
    FN_RSV_F    = 4'd15
  } alu_fn_e;

  typedef enum logic [1:0] {
    SH_PASS  = 2'd0,
    SH_LEFT  = 2'd1,
    SH_RIGHT = 2'd2,
    SH_SWAP  = 2'd3
  } shift_op_e;

  // T load source: 1 = ALU result, 0 = bus
  function automatic logic t_from_alu(alu_fn_e fn);
    case (fn)
      FN_PASS_BUS, FN_OR, FN_INC, FN_DEC,
      FN_ADD_INC, FN_ADD_SKIP, FN_AND_ALT: t_from_alu = 1'b1;
      default:                             t_from_alu = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/alu_core.sv
module alu_core
  import alu_dp_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  alu_fn_e          fn_i,
  input  logic [WIDTH-1:0] bus_i,
  input  logic [WIDTH-1:0] t_i,
  input  logic             skip_i,
  output logic [WIDTH-1:0] res_o,
  output logic             carry_o
);

  logic [WIDTH-1:0] add_b;
  logic             add_cin;
  logic             is_arith;
  logic [WIDTH:0]   sum;
  logic [WIDTH-1:0] logic_res;

  always_comb begin
    add_b     = '0;
    add_cin   = 1'b0;
    is_arith  = 1'b1;
    logic_res = '0;
    case (fn_i)
      FN_PASS_BUS: begin is_arith = 1'b0; logic_res = bus_i;          end
      FN_PASS_T:   begin is_arith = 1'b0; logic_res = t_i;            end
      FN_OR:       begin is_arith = 1'b0; logic_res = bus_i | t_i;    end
      FN_AND,
      FN_AND_ALT:  begin is_arith = 1'b0; logic_res = bus_i & t_i;    end
      FN_XOR:      begin is_arith = 1'b0; logic_res = bus_i ^ t_i;    end
      FN_AND_NOT:  begin is_arith = 1'b0; logic_res = bus_i & ~t_i;   end
      FN_INC:      add_cin = 1'b1;
      FN_DEC:      add_b   = '1;
      FN_ADD:      add_b   = t_i;
      FN_ADD_INC:  begin add_b = t_i;  add_cin = 1'b1; end
      FN_SUB:      begin add_b = ~t_i; add_cin = 1'b1; end
      FN_SUB_DEC:  add_b   = ~t_i;
      FN_ADD_SKIP: add_cin = ~skip_i;
      default:     is_arith = 1'b0;  // reserved codes: zero
    endcase
  end

  assign sum     = {1'b0, bus_i} + {1'b0, add_b} + {{WIDTH{1'b0}}, add_cin};
  assign res_o   = is_arith ? sum[WIDTH-1:0] : logic_res;
  assign carry_o = is_arith & sum[WIDTH];

  // R4: reserved codes give zero and no carry
  a_r4_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fn_i == FN_RSV_E || fn_i == FN_RSV_F) |-> (res_o == '0 && !carry_o));

  // R3: skip set passes the bus through
  a_r3_skip_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fn_i == FN_ADD_SKIP && skip_i) |-> (res_o == bus_i && !carry_o));

  // R1: logic functions never carry
  a_r1_logic_no_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fn_i inside {FN_PASS_BUS, FN_PASS_T, FN_OR, FN_AND, FN_XOR, FN_AND_ALT, FN_AND_NOT})
    |-> !carry_o);

endmodule

// File: rtl/l_shifter.sv
module l_shifter
  import alu_dp_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  shift_op_e        op_i,
  input  logic [WIDTH-1:0] l_i,
  output logic [WIDTH-1:0] sh_o,
  output logic             neg_o,
  output logic             zero_o
);

  localparam int HALF = WIDTH / 2;

  always_comb begin
    case (op_i)
      SH_LEFT:  sh_o = {l_i[WIDTH-2:0], 1'b0};
      SH_RIGHT: sh_o = {1'b0, l_i[WIDTH-1:1]};
      SH_SWAP:  sh_o = {l_i[HALF-1:0], l_i[WIDTH-1:HALF]};
      default:  sh_o = l_i;
    endcase
  end

  assign neg_o  = sh_o[WIDTH-1];
  assign zero_o = ~|sh_o;

  // R10: fill bits are zero, rotation keeps the bit count
  a_r10_left_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == SH_LEFT) |-> (sh_o[0] == 1'b0 && sh_o[WIDTH-1] == l_i[WIDTH-2]));
  a_r10_right_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == SH_RIGHT) |-> (sh_o[WIDTH-1] == 1'b0 && sh_o[0] == l_i[1]));
  a_r10_swap_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == SH_SWAP) |-> ($countones(sh_o) == $countones(l_i)));
  // R11: zero flag agrees with the negative flag
  a_r11_zero_not_neg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_o |-> !neg_o);

endmodule

// File: rtl/alu_tl_datapath.sv
module alu_tl_datapath
  import alu_dp_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [3:0]       aluf_i,
  input  logic [WIDTH-1:0] bus_i,
  input  logic             bus_drive_i,
  input  logic             skip_i,
  input  logic             load_t_i,
  input  logic             load_l_i,
  input  logic [1:0]       shift_op_i,
  output logic [WIDTH-1:0] alu_o,
  output logic             carry_o,
  output logic [WIDTH-1:0] t_o,
  output logic [WIDTH-1:0] l_o,
  output logic             carry_q_o,
  output logic [WIDTH-1:0] shift_o,
  output logic             shift_neg_o,
  output logic             shift_zero_o
);

  localparam logic [WIDTH-1:0] BUS_OPEN = '1;  // wired-AND idle value

  alu_fn_e          fn;
  logic [WIDTH-1:0] bus_eff;
  logic [WIDTH-1:0] t_q, l_q;
  logic             cy_q;

  assign fn      = alu_fn_e'(aluf_i);
  assign bus_eff = bus_drive_i ? bus_i : BUS_OPEN;

  alu_core #(.WIDTH(WIDTH)) u_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fn_i    (fn),
    .bus_i   (bus_eff),
    .t_i     (t_q),
    .skip_i  (skip_i),
    .res_o   (alu_o),
    .carry_o (carry_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      t_q  <= '0;
      l_q  <= '0;
      cy_q <= 1'b0;
    end else begin
      if (load_t_i) t_q <= t_from_alu(fn) ? alu_o : bus_eff;
      if (load_l_i) begin
        l_q  <= alu_o;
        cy_q <= carry_o;
      end
    end
  end

  l_shifter #(.WIDTH(WIDTH)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .op_i   (shift_op_e'(shift_op_i)),
    .l_i    (l_q),
    .sh_o   (shift_o),
    .neg_o  (shift_neg_o),
    .zero_o (shift_zero_o)
  );

  assign t_o       = t_q;
  assign l_o       = l_q;
  assign carry_q_o = cy_q;

  a_r6_t_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_t_i |=> $stable(t_o));
  a_r7_l_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_l_i |=> (l_o == $past(alu_o)));
  a_r7_l_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_l_i |=> $stable(l_o));
  a_r8_carry_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_l_i |=> (carry_q_o == $past(carry_o)));
  a_r8_carry_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_l_i |=> $stable(carry_q_o));
  a_r9_open_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_drive_i && aluf_i == 4'd0) |-> (alu_o == BUS_OPEN));
  a_r4_t_from_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_t_i && aluf_i >= 4'd14) |=> (t_o == $past(bus_eff)));

endmodule

// File: tb/alu_tl_datapath_test.sv
`timescale 1ns/1ps
module alu_tl_datapath_test;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [3:0]   aluf = '0;
  logic [W-1:0] bus = '0;
  logic         bus_drive = 1'b1;
  logic         skip = 1'b0;
  logic         load_t = 1'b0;
  logic         load_l = 1'b0;
  logic [1:0]   shop = '0;
  logic [W-1:0] alu_o, t_o, l_o, shift_o;
  logic         carry_o, carry_q_o, shift_neg_o, shift_zero_o;

  int n_chk = 0;
  int n_bad = 0;

  logic [W-1:0] m_t, m_l;
  logic         m_c;

  always #4 clk = ~clk;

  alu_tl_datapath #(.WIDTH(W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .aluf_i(aluf), .bus_i(bus),
    .bus_drive_i(bus_drive), .skip_i(skip), .load_t_i(load_t),
    .load_l_i(load_l), .shift_op_i(shop), .alu_o(alu_o), .carry_o(carry_o),
    .t_o(t_o), .l_o(l_o), .carry_q_o(carry_q_o), .shift_o(shift_o),
    .shift_neg_o(shift_neg_o), .shift_zero_o(shift_zero_o)
  );

  function automatic logic [W:0] ref_alu(logic [3:0] f, logic [W-1:0] b,
                                          logic [W-1:0] t, logic s);
    logic [W:0] r;
    case (f)
      4'd0:  r = {1'b0, b};
      4'd1:  r = {1'b0, t};
      4'd2:  r = {1'b0, b | t};
      4'd3:  r = {1'b0, b & t};
      4'd4:  r = {1'b0, b ^ t};
      4'd5:  r = {1'b0, b} + 17'd1;
      4'd6:  r = {1'b0, b} + 17'h0FFFF;
      4'd7:  r = {1'b0, b} + {1'b0, t};
      4'd8:  r = {1'b0, b} + {1'b0, ~t} + 17'd1;
      4'd9:  r = {1'b0, b} + {1'b0, ~t};
      4'd10: r = {1'b0, b} + {1'b0, t} + 17'd1;
      4'd11: r = {1'b0, b} + (s ? 17'd0 : 17'd1);
      4'd12: r = {1'b0, b & t};
      4'd13: r = {1'b0, b & ~t};
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic logic ref_tsel(logic [3:0] f);
    return (f == 4'd0 || f == 4'd2 || f == 4'd5 || f == 4'd6 ||
            f == 4'd10 || f == 4'd11 || f == 4'd12);
  endfunction

  function automatic logic [W-1:0] ref_shift(logic [1:0] op, logic [W-1:0] l);
    case (op)
      2'd1:    return {l[W-2:0], 1'b0};
      2'd2:    return {1'b0, l[W-1:1]};
      2'd3:    return {l[7:0], l[15:8]};
      default: return l;
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h (aluf=%0d)", req, act, exp, aluf);
    end
  endtask

  function automatic string alu_tag(logic [3:0] f);
    if (f == 4'd11) return "R3";
    if (f >= 4'd14) return "R4";
    if (f >= 4'd5 && f <= 4'd10) return "R2";
    return "R1";
  endfunction

  // one cycle: drive at negedge, check comb, clock, update model
  task automatic step(logic [3:0] f, logic [W-1:0] b, logic drv, logic s,
                      logic lt, logic ll, logic [1:0] op);
    logic [W:0]   r;
    logic [W-1:0] be;
    @(negedge clk);
    aluf = f; bus = b; bus_drive = drv; skip = s;
    load_t = lt; load_l = ll; shop = op;
    #1;
    be = drv ? b : '1;
    r  = ref_alu(f, be, m_t, s);
    check(drv ? alu_tag(f) : "R9", {16'd0, alu_o}, {16'd0, r[W-1:0]});
    check(drv ? alu_tag(f) : "R9", {31'd0, carry_o}, {31'd0, r[W]});
    check("R10", {16'd0, shift_o}, {16'd0, ref_shift(op, m_l)});
    check("R11", {30'd0, shift_neg_o, shift_zero_o},
          {30'd0, ref_shift(op, m_l)[W-1], ref_shift(op, m_l) == '0});
    @(posedge clk);
    if (lt) m_t = ref_tsel(f) ? r[W-1:0] : be;
    if (ll) begin m_l = r[W-1:0]; m_c = r[W]; end
    #1;
    check(lt ? (f >= 4'd14 ? "R4" : "R5") : "R6", {16'd0, t_o}, {16'd0, m_t});
    check("R7", {16'd0, l_o}, {16'd0, m_l});
    check("R8", {31'd0, carry_q_o}, {31'd0, m_c});
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual running expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] rnd;
    void'($urandom(32'd1234));
    m_t = '0; m_l = '0; m_c = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R12", {16'd0, t_o}, 32'd0);
    check("R12", {16'd0, l_o}, 32'd0);
    check("R12", {31'd0, carry_q_o}, 32'd0);
    @(negedge clk);
    rst_ni = 1'b1;

    // directed corners
    step(4'd0, 16'h1234, 1'b1, 1'b0, 1'b1, 1'b1, 2'd0);   // T=L=1234
    step(4'd7, 16'hEDCC, 1'b1, 1'b0, 1'b0, 1'b1, 2'd0);   // R2 0x10000 carry
    step(4'd8, 16'h1234, 1'b1, 1'b0, 1'b0, 1'b1, 2'd3);   // R2 equal sub
    step(4'd9, 16'h1234, 1'b1, 1'b0, 1'b0, 1'b1, 2'd1);   // R2 sub-1 borrow
    step(4'd11, 16'hFFFF, 1'b1, 1'b0, 1'b0, 1'b1, 2'd0);  // R3 wrap
    step(4'd11, 16'hFFFF, 1'b1, 1'b1, 1'b0, 1'b1, 2'd0);  // R3 pass
    step(4'd14, 16'hABCD, 1'b1, 1'b0, 1'b1, 1'b1, 2'd2);  // R4
    step(4'd15, 16'h5555, 1'b1, 1'b0, 1'b1, 1'b0, 2'd0);  // R4
    step(4'd0, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b1, 2'd2);   // R9 open bus
    step(4'd5, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b1, 2'd0);   // R9 + R2 carry
    step(4'd6, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b1, 2'd3);   // R2 0-1
    step(4'd1, 16'h8000, 1'b1, 1'b0, 1'b0, 1'b1, 2'd1);

    for (int i = 0; i < 1500; i++) begin
      logic [3:0]  f;
      logic [15:0] b;
      rnd = $urandom;
      f = rnd[3:0];
      rnd = $urandom;
      b = rnd[15:0];
      if (rnd[18:16] == 3'd0) b = 16'hFFFF;
      if (rnd[18:16] == 3'd1) b = m_t;
      step(f, b, rnd[21:19] != 3'd0, rnd[22], rnd[23], rnd[24], rnd[26:25]);
    end

    @(negedge clk);
    rst_ni = 1'b0;
    m_t = '0; m_l = '0; m_c = 1'b0;
    #1;
    check("R12", {16'd0, t_o}, 32'd0);
    check("R12", {16'd0, l_o}, 32'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule